// File: doc/BRIEF.md
# Delayed Host Bus Request Controller

This block produces the active-low host bus request for a bridge that posts writes from a local master onto a host bus. When a posted write becomes pending and its first data word has arrived, the request is held back for a programmable number of host clocks. The write buffer can then collect more burst data before the bus is requested. Read transactions request the bus at once.

Once the grant is seen the request is withdrawn and the block tracks the ownership period. If the target disconnects, the request is forced off for a fixed gap. It is raised again, with no extra write delay, if the transaction is still pending. When a transaction is cancelled or completes, the block returns to idle. The next write then has to present a new first-data strobe and waits out its full delay. The buffer, the data path and the bus protocol engine sit outside this block.

Top module: `breq_delay_ctrl`

## Requirements
- R1: `rst` is a synchronous active-high reset. On the clock after it is sampled high, `req_n` is 1 and any running delay is discarded.
- R2: With no transaction pending, `req_n` stays 1 (deasserted).
- R3: With `dly_sel` = 2'b00, a write start asserts `req_n` (0) in the cycle right after the start edge. A write start is `xact_pend`=1, `xact_wr`=1 and `wr_first`=1 sampled together while idle.
- R4: With `dly_sel` of 2'b01, 2'b10 or 2'b11, `req_n` asserts 4, 8 or 16 clocks later than in the R3 case.
- R5: A read start is `xact_pend`=1 with `xact_wr`=0 while idle. It asserts `req_n` in the next cycle whatever the value of `dly_sel`.
- R6: If `xact_pend` drops, `req_n` is 1 from the next cycle on. A delay count in progress is abandoned.
- R7: A `tgt_disc` pulse sampled during ownership keeps `req_n` at 1 for at least two clocks. After that, `req_n` asserts again with no write delay if `xact_pend` is still 1.
- R8: If `gnt_n`=0 is sampled while `req_n`=0, `req_n` returns to 1 on the next clock and stays at 1 during ownership.
- R9: After a cancel or a completion, a new write delay starts only on a fresh `wr_first` strobe, and it runs the full delay. A pending write without that strobe never asserts `req_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous reset, active high |
| dly_sel | input | 2 | Write request delay code: 00=0, 01=4, 10=8, 11=16 clocks |
| wr_first | input | 1 | Strobe: first write word received from the local master |
| xact_pend | input | 1 | A host transaction is pending and ready to start |
| xact_wr | input | 1 | 1 = the pending transaction is a write, 0 = a read |
| gnt_n | input | 1 | Host bus grant, active low |
| tgt_disc | input | 1 | Target disconnect ended the current ownership |
| req_n | output | 1 | Host bus request, active low |

## Verification
The bench uses the default parameters: a delay unit of 4 clocks and a disconnect gap of 2 clocks. With these values the longest delay is 16 clocks, so every delay code, including the 16-clock one, can be measured exactly within a short run. The two-clock gap after a disconnect can also be checked cycle by cycle. Random sequences mix read and write starts across all delay codes. Directed cases cover a cancel in mid-count, a reset in mid-count and re-arming without a strobe.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_REQ  = 3'd2,
        ST_OWN  = 3'd3,
        ST_GAP  = 3'd4
    } bdr_state_e;

    // Delay code to clock count: 0, 1, 2 or 4 units.
    function automatic int unsigned dly_clocks(input logic [1:0] sel,
                                               input int unsigned unit);
        case (sel)
            2'b00:   return 0;
            2'b01:   return unit;
            2'b10:   return 2 * unit;
            default: return 4 * unit;
        endcase
    endfunction

endpackage

// File: rtl/bdr_down_cnt.sv
module bdr_down_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign at_one = (cnt == W'(1));
endmodule

// File: rtl/bdr_fsm.sv
module bdr_fsm
    import bdr_pkg::*;
#(
    parameter int W        = 5,
    parameter int GAP_CLKS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wr_dly,
    input  logic         wr_first,
    input  logic         xact_pend,
    input  logic         xact_wr,
    input  logic         gnt_n,
    input  logic         tgt_disc,
    input  logic         at_one,
    output logic         cnt_clr,
    output logic         cnt_load,
    output logic [W-1:0] cnt_val,
    output logic         cnt_dec,
    output bdr_state_e   st
);
    bdr_state_e nxt;
    logic       start_wr;

    assign start_wr = xact_pend && xact_wr && wr_first;

    always_comb begin
        nxt      = st;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = wr_dly;
        cnt_dec  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (xact_pend && !xact_wr) begin
                    nxt = ST_REQ;
                end else if (start_wr) begin
                    if (wr_dly == '0) begin
                        nxt = ST_REQ;
                    end else begin
                        nxt      = ST_WAIT;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!xact_pend) begin
                    nxt     = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (at_one) begin
                    nxt     = ST_REQ;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_REQ: begin
                if (!xact_pend)  nxt = ST_IDLE;
                else if (!gnt_n) nxt = ST_OWN;
            end
            ST_OWN: begin
                if (tgt_disc) begin
                    nxt      = ST_GAP;
                    cnt_load = 1'b1;
                    cnt_val  = W'(GAP_CLKS);
                end else if (!xact_pend) begin
                    nxt = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (!xact_pend) begin
                    nxt     = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (at_one) begin
                    nxt     = ST_REQ;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/breq_delay_ctrl.sv
module breq_delay_ctrl
    import bdr_pkg::*;
#(
    parameter int DLY_UNIT = 4,
    parameter int GAP_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] dly_sel,
    input  logic       wr_first,
    input  logic       xact_pend,
    input  logic       xact_wr,
    input  logic       gnt_n,
    input  logic       tgt_disc,
    output logic       req_n
);
    localparam int MAX_CNT = (4 * DLY_UNIT > GAP_CLKS) ? 4 * DLY_UNIT : GAP_CLKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] wr_dly;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_clr, cnt_load, cnt_dec, at_one;
    bdr_state_e       st;

    assign wr_dly = CNT_W'(dly_clocks(dly_sel, DLY_UNIT));

    bdr_down_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .at_one   (at_one)
    );

    bdr_fsm #(.W(CNT_W), .GAP_CLKS(GAP_CLKS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_dly    (wr_dly),
        .wr_first  (wr_first),
        .xact_pend (xact_pend),
        .xact_wr   (xact_wr),
        .gnt_n     (gnt_n),
        .tgt_disc  (tgt_disc),
        .at_one    (at_one),
        .cnt_clr   (cnt_clr),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_dec   (cnt_dec),
        .st        (st)
    );

    assign req_n = (st != ST_REQ);
endmodule

// File: rtl/breq_delay_ctrl_chk.sv
module breq_delay_ctrl_chk
    import bdr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] dly_sel,
    input logic       wr_first,
    input logic       xact_pend,
    input logic       xact_wr,
    input logic       gnt_n,
    input logic       tgt_disc,
    input logic       req_n,
    input bdr_state_e st
);
    // Cycles since the last disconnect, saturating at 3.
    logic [1:0] since_disc;
    always_ff @(posedge clk) begin
        if (rst)                 since_disc <= 2'd3;
        else if (tgt_disc)       since_disc <= 2'd0;
        else if (since_disc != 2'd3) since_disc <= since_disc + 2'd1;
    end

    AST_RESET_OFF: assert property (@(posedge clk) rst |=> req_n); // R1
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !xact_pend) |=> req_n); // R2
    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && xact_pend && xact_wr && wr_first && dly_sel == 2'b00) |=> !req_n); // R3
    AST_READ_NODELAY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && xact_pend && !xact_wr) |=> !req_n); // R5
    AST_CANCEL_OFF: assert property (@(posedge clk) disable iff (rst)
        !xact_pend |=> req_n); // R6
    AST_DISC_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n) |-> since_disc >= 2'd2); // R7
    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
        (!req_n && !gnt_n) |=> req_n); // R8
endmodule

bind breq_delay_ctrl breq_delay_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dly_sel   (dly_sel),
    .wr_first  (wr_first),
    .xact_pend (xact_pend),
    .xact_wr   (xact_wr),
    .gnt_n     (gnt_n),
    .tgt_disc  (tgt_disc),
    .req_n     (req_n),
    .st        (st)
);

// File: tb/sim_breq_delay_ctrl.sv
module sim_breq_delay_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] dly_sel;
    logic       wr_first, xact_pend, xact_wr, gnt_n, tgt_disc;
    logic       req_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    breq_delay_ctrl u0 (
        .clk(clk), .rst(rst), .dly_sel(dly_sel), .wr_first(wr_first),
        .xact_pend(xact_pend), .xact_wr(xact_wr), .gnt_n(gnt_n),
        .tgt_disc(tgt_disc), .req_n(req_n)
    );

    function automatic int exp_dly(input logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Grant the bus and complete the transaction.
    task automatic grant_done();
        gnt_n = 1'b0;
        step();
        chk("R8 req off after grant", int'(req_n), 1);
        gnt_n = 1'b1;
        xact_pend = 1'b0;
        step();
        chk("R8 req off while owning/done", int'(req_n), 1);
    endtask

    // Start a write and measure the clocks until req_n asserts.
    task automatic run_write(input logic [1:0] s, input string req);
        int c;
        dly_sel = s; xact_pend = 1'b1; xact_wr = 1'b1; wr_first = 1'b1;
        step();
        wr_first = 1'b0;
        c = 0;
        while (req_n && c < 40) begin
            step();
            c++;
        end
        chk(req, c, exp_dly(s));
        grant_done();
    endtask

    task automatic run_read(input logic [1:0] s);
        dly_sel = s; xact_pend = 1'b1; xact_wr = 1'b0; wr_first = 1'b0;
        step();
        chk("R5 read requests at once", int'(req_n), 0);
        grant_done();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; dly_sel = 2'b00; wr_first = 1'b0; xact_pend = 1'b0;
        xact_wr = 1'b0; gnt_n = 1'b1; tgt_disc = 1'b0;
        step(); step();
        chk("R1 reset state", int'(req_n), 1);
        rst = 1'b0;
        repeat (3) step();
        chk("R2 idle with nothing pending", int'(req_n), 1);

        // R3 / R4: every delay code
        run_write(2'b00, "R3 zero delay");
        run_write(2'b01, "R4 delay 4");
        run_write(2'b10, "R4 delay 8");
        run_write(2'b11, "R4 delay 16");

        // R5: read ignores the delay code
        run_read(2'b11);

        // R6: cancel in mid-count
        dly_sel = 2'b10; xact_pend = 1'b1; xact_wr = 1'b1; wr_first = 1'b1;
        step();
        wr_first = 1'b0;
        step(); step();
        xact_pend = 1'b0;
        step();
        chk("R6 cancel keeps req off", int'(req_n), 1);
        begin
            int low = 0;
            for (int i = 0; i < 12; i++) begin
                step();
                if (!req_n) low++;
            end
            chk("R6 no request after cancel", low, 0);
        end

        // R9: pending write without fresh strobe never requests
        xact_pend = 1'b1; xact_wr = 1'b1;
        begin
            int low = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (!req_n) low++;
            end
            chk("R9 no strobe no request", low, 0);
        end
        xact_pend = 1'b0;
        step();
        run_write(2'b11, "R9 full delay after rearm");

        // R1: reset during count clears it
        dly_sel = 2'b11; xact_pend = 1'b1; xact_wr = 1'b1; wr_first = 1'b1;
        step();
        wr_first = 1'b0;
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        begin
            int low = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (!req_n) low++;
            end
            chk("R1 reset discards count", low, 0);
        end
        xact_pend = 1'b0;
        step();

        // R7: disconnect gap
        dly_sel = 2'b10; xact_pend = 1'b1; xact_wr = 1'b1; wr_first = 1'b1;
        step();
        wr_first = 1'b0;
        repeat (8) step();
        chk("R4 delay 8 before disconnect", int'(req_n), 0);
        gnt_n = 1'b0;
        step();
        gnt_n = 1'b1;
        step();
        tgt_disc = 1'b1;
        step();
        tgt_disc = 1'b0;
        chk("R7 gap cycle 1", int'(req_n), 1);
        step();
        chk("R7 gap cycle 2", int'(req_n), 1);
        step();
        chk("R7 reassert after gap without delay", int'(req_n), 0);
        grant_done();

        // Random mix
        for (int n = 0; n < 30; n++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) run_read(s);
            else run_write(s, s == 2'b00 ? "R3 random write" : "R4 random write");
            repeat ($urandom_range(0, 3)) step();
            chk("R2 idle between transactions", int'(req_n), 1);
        end

        summary();
    end
endmodule